// File: doc/BRIEF.md
# Chip Control Register Bank with Raster Beam Counter

This block is the control-register front end of a video and DMA coprocessor chip. It sits on a 16-bit processor-style bus that carries a byte offset, an access strobe, a write flag and 16-bit data. It holds three 15-bit control words: DMA enables, interrupt enables and pending interrupt requests. Software changes these words with a single masked write. Bit 15 of the data chooses whether the 15-bit mask in bits 14:0 sets bits or clears them, so two bus masters never need a read-modify-write.

The block also keeps a free-running raster beam position. One counter tracks the dot position within a line and one tracks the line number. Both advance only when the beam clock enable is high. Every odd line is one count longer than every even line. Software reads the position on two addresses. The block drives one interrupt line from the enabled pending requests. Writes to the other chip functions on the same bus (bitplanes, sprites, blitter, coprocessor, palette) are accepted and change nothing. The six bitplane data words read back as all ones.

Top module: `chip_regbank`

## Requirements
- R1: A write with data bit 15 = 1 to a control word ORs data bits 14:0 into it and leaves its other bits unchanged.
- R2: A write with data bit 15 = 0 to a control word clears every bit where data bits 14:0 are 1 and leaves the others unchanged.
- R3: The DMA control word is written at offset 0x096. A read at offset 0x002 returns {1'b0, DMA word} bitwise ORed with the 16-bit blit status input.
- R4: The interrupt enable word is written at 0x09A and the request word at 0x09C. `irq_out` is high exactly when enable bit 14 is 1 and (enable[13:0] & request[13:0]) is nonzero. It reflects a write from the cycle after that write.
- R5: Address bit 0 plays no part in decode: offsets 2k and 2k+1 reach the same register for reads and for writes.
- R6: The dot counter counts 0..226 on even lines and 0..227 on odd lines, then returns to 0.
- R7: The line counter advances by one when the dot counter returns to 0. After line 261 it goes back to line 0.
- R8: A read at 0x004 returns the line count shifted right by 8. A read at 0x006 returns the dot count in bits 15:8 and line count bits 7:0 in bits 7:0.
- R9: Reads of offsets 0x110 through 0x11B return 0xFFFF.
- R10: Reads of any other offset, including the write-only offsets 0x096, 0x09A and 0x09C, return 0x0000. Writes to any offset other than 0x096, 0x09A and 0x09C change no register.
- R11: A synchronous active-high reset sets all three control words and both beam counters to 0, so `irq_out` is 0 after reset.
- R12: While `beam_ce` is low, both beam counters hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| beam_ce | input | 1 | Beam counter advance enable |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset; bits 11:1 decoded |
| bus_wdata | input | 16 | Write data; bit 15 selects set or clear |
| blit_status | input | 16 | Status bits merged into the DMA read |
| bus_rdata | output | 16 | Read data, combinational, 0 when not reading |
| irq_out | output | 1 | Interrupt request output |

## Verification
The bench goes after the long odd line. It stops the beam at dot 226 and at dot 227 of lines 0 and 1. A counter that used a fixed line length would show line 1 one dot early, or let an even line reach 227. It checks the frame wrap at line 261 and the line-256 crossing seen on the high position read. An off-by-one limit would leave line 262 visible, and a wrong shift would leave the high read at 0. It also checks that the master enable bit gates the interrupt, that clearing a request drops the line, that odd addresses alias even ones, and that writes to read-only or foreign offsets leave the control words alone. A decode that trusted address bit 0 or matched too widely would corrupt the DMA readback.

// File: rtl/chip_regbank_pkg.sv
package chip_regbank_pkg;

    localparam int BUS_DATA_W = 16;
    localparam int CTRL_W     = BUS_DATA_W - 1;

    localparam logic [11:0] OFS_DMA_RD  = 12'h002;
    localparam logic [11:0] OFS_POS_HI  = 12'h004;
    localparam logic [11:0] OFS_POS_LO  = 12'h006;
    localparam logic [11:0] OFS_DMA_WR  = 12'h096;
    localparam logic [11:0] OFS_IEN_WR  = 12'h09A;
    localparam logic [11:0] OFS_IREQ_WR = 12'h09C;
    localparam logic [11:0] OFS_BPL_LO  = 12'h110;
    localparam logic [11:0] OFS_BPL_HI  = 12'h11A;

    localparam int NUM_CTRL = 3;
    localparam int CTRL_DMA = 0;
    localparam int CTRL_IEN = 1;
    localparam int CTRL_IRQ = 2;

    localparam int IEN_MASTER_BIT = 14;

    function automatic logic [11:0] ctrl_wr_offset(int idx);
        case (idx)
            CTRL_DMA: return OFS_DMA_WR;
            CTRL_IEN: return OFS_IEN_WR;
            default:  return OFS_IREQ_WR;
        endcase
    endfunction

endpackage

// File: rtl/cr_setclr_reg.sv
module cr_setclr_reg #(
    parameter int          DATA_W   = 16,
    parameter int          WA_W     = 11,
    parameter logic [11:0] WORD_OFS = 12'h096,
    localparam int         W        = DATA_W - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WA_W-1:0]   word_addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [W-1:0]      value
);

    localparam logic [WA_W-1:0] WORD_IDX = WA_W'(WORD_OFS >> 1);

    typedef struct packed {
        logic [W-1:0] bits;
    } sc_state_t;

    sc_state_t st_d, st_q;
    logic      hit;

    always_comb begin
        hit  = wr_en && (word_addr == WORD_IDX);
        st_d = st_q;
        if (hit) begin
            if (wdata[DATA_W-1]) begin
                st_d.bits = st_q.bits | wdata[W-1:0];
            end else begin
                st_d.bits = st_q.bits & ~wdata[W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign value = st_q.bits;

    // R1
    set_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && wdata[DATA_W-1]) |=>
        ((value & $past(wdata[W-1:0])) == $past(wdata[W-1:0])));

    // R2
    clear_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && !wdata[DATA_W-1]) |=> ((value & $past(wdata[W-1:0])) == '0));

    // R10
    no_hit_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !hit |=> $stable(value));

endmodule

// File: rtl/cr_beam_counter.sv
module cr_beam_counter #(
    parameter int  H_BASE  = 227,
    parameter int  V_LINES = 262,
    localparam int H_W     = $clog2(H_BASE + 1),
    localparam int V_W     = $clog2(V_LINES)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           ce,
    output logic [H_W-1:0] h_pos,
    output logic [V_W-1:0] v_pos
);

    localparam logic [H_W-1:0] H_LAST_EVEN = H_W'(H_BASE - 1);
    localparam logic [V_W-1:0] V_LAST      = V_W'(V_LINES - 1);

    typedef struct packed {
        logic [H_W-1:0] h;
        logic [V_W-1:0] v;
    } beam_state_t;

    beam_state_t    st_d, st_q;
    logic [H_W-1:0] h_end;

    always_comb begin
        h_end = H_LAST_EVEN + H_W'(st_q.v[0]);
        st_d  = st_q;
        if (ce) begin
            if (st_q.h == h_end) begin
                st_d.h = '0;
                st_d.v = (st_q.v == V_LAST) ? '0 : st_q.v + 1'b1;
            end else begin
                st_d.h = st_q.h + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign h_pos = st_q.h;
    assign v_pos = st_q.v;

    // R6
    h_range_chk: assert property (@(posedge clk) disable iff (rst)
        h_pos <= H_W'(H_BASE));

    // R6
    even_line_short_chk: assert property (@(posedge clk) disable iff (rst)
        !v_pos[0] |-> (h_pos != H_W'(H_BASE)));

    // R7
    v_range_chk: assert property (@(posedge clk) disable iff (rst)
        v_pos <= V_LAST);

    // R7
    v_step_on_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (h_pos != '0) |-> (v_pos == $past(v_pos)));

    // R12
    ce_low_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ce |=> ($stable(h_pos) && $stable(v_pos)));

endmodule

// File: rtl/cr_read_mux.sv
module cr_read_mux
    import chip_regbank_pkg::*;
#(
    parameter int  DATA_W = 16,
    parameter int  WA_W   = 11,
    parameter int  H_W    = 8,
    parameter int  V_W    = 9,
    localparam int W      = DATA_W - 1
) (
    input  logic              rd_en,
    input  logic [WA_W-1:0]   word_addr,
    input  logic [W-1:0]      dma_value,
    input  logic [DATA_W-1:0] blit_status,
    input  logic [H_W-1:0]    h_pos,
    input  logic [V_W-1:0]    v_pos,
    output logic [DATA_W-1:0] rdata
);

    localparam logic [WA_W-1:0] W_DMA  = WA_W'(OFS_DMA_RD >> 1);
    localparam logic [WA_W-1:0] W_PHI  = WA_W'(OFS_POS_HI >> 1);
    localparam logic [WA_W-1:0] W_PLO  = WA_W'(OFS_POS_LO >> 1);
    localparam logic [WA_W-1:0] W_BPL0 = WA_W'(OFS_BPL_LO >> 1);
    localparam logic [WA_W-1:0] W_BPL5 = WA_W'(OFS_BPL_HI >> 1);

    logic [DATA_W-1:0] pos_hi_d, pos_lo_d, dma_rd_d;

    always_comb begin
        dma_rd_d = {1'b0, dma_value} | blit_status;
        pos_hi_d = DATA_W'(v_pos >> 8);
        pos_lo_d = DATA_W'({8'(h_pos), 8'(v_pos)});
        rdata    = '0;
        if (rd_en) begin
            if (word_addr == W_DMA) begin
                rdata = dma_rd_d;
            end else if (word_addr == W_PHI) begin
                rdata = pos_hi_d;
            end else if (word_addr == W_PLO) begin
                rdata = pos_lo_d;
            end else if (word_addr >= W_BPL0 && word_addr <= W_BPL5) begin
                rdata = '1;
            end
        end
    end

    // R10
    idle_zero_chk: assert final (rd_en || rdata == '0);

endmodule

// File: rtl/chip_regbank.sv
module chip_regbank
    import chip_regbank_pkg::*;
#(
    parameter int  ADDR_W  = 12,
    parameter int  DATA_W  = BUS_DATA_W,
    parameter int  H_BASE  = 227,
    parameter int  V_LINES = 262,
    localparam int WA_W    = ADDR_W - 1,
    localparam int W       = DATA_W - 1,
    localparam int H_W     = $clog2(H_BASE + 1),
    localparam int V_W     = $clog2(V_LINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              beam_ce,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] blit_status,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_out
);

    logic [WA_W-1:0] word_addr;
    logic            wr_en, rd_en;
    logic            unused_byte_sel;
    logic [W-1:0]    ctrl_q [NUM_CTRL];
    logic [H_W-1:0]  h_pos;
    logic [V_W-1:0]  v_pos;
    logic            irq_d;

    assign word_addr       = bus_addr[ADDR_W-1:1];
    assign unused_byte_sel = bus_addr[0];
    assign wr_en           = bus_sel && bus_we;
    assign rd_en           = bus_sel && !bus_we;

    for (genvar i = 0; i < NUM_CTRL; i++) begin : g_ctrl
        cr_setclr_reg #(
            .DATA_W  (DATA_W),
            .WA_W    (WA_W),
            .WORD_OFS(ctrl_wr_offset(i))
        ) u_reg (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (wr_en),
            .word_addr(word_addr),
            .wdata    (bus_wdata),
            .value    (ctrl_q[i])
        );
    end

    cr_beam_counter #(
        .H_BASE (H_BASE),
        .V_LINES(V_LINES)
    ) u_beam (
        .clk  (clk),
        .rst  (rst),
        .ce   (beam_ce),
        .h_pos(h_pos),
        .v_pos(v_pos)
    );

    cr_read_mux #(
        .DATA_W(DATA_W),
        .WA_W  (WA_W),
        .H_W   (H_W),
        .V_W   (V_W)
    ) u_rd (
        .rd_en      (rd_en),
        .word_addr  (word_addr),
        .dma_value  (ctrl_q[CTRL_DMA]),
        .blit_status(blit_status),
        .h_pos      (h_pos),
        .v_pos      (v_pos),
        .rdata      (bus_rdata)
    );

    always_comb begin
        irq_d = ctrl_q[CTRL_IEN][IEN_MASTER_BIT] &&
                (|(ctrl_q[CTRL_IEN][IEN_MASTER_BIT-1:0] &
                   ctrl_q[CTRL_IRQ][IEN_MASTER_BIT-1:0]));
    end

    assign irq_out = irq_d;

    // R4
    irq_master_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && word_addr == WA_W'(OFS_IEN_WR >> 1) &&
         !bus_wdata[DATA_W-1] && bus_wdata[IEN_MASTER_BIT]) |=> !irq_out);

    // R4
    irq_clear_all_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && word_addr == WA_W'(OFS_IREQ_WR >> 1) &&
         bus_wdata == {1'b0, {W{1'b1}}}) |=> !irq_out);

endmodule

// File: tb/chip_regbank_test.sv
module chip_regbank_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        beam_ce = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] blit_status = '0;
    logic [15:0] bus_rdata;
    logic        irq_out;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    logic [14:0] m_dma = '0, m_ien = '0, m_req = '0;
    int          m_h = 0, m_v = 0;

    always #4 clk = ~clk;

    chip_regbank uut (
        .clk(clk), .rst(rst), .beam_ce(beam_ce), .bus_sel(bus_sel),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .blit_status(blit_status), .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    // beam model from R6, R7, R11, R12
    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_h = 0; m_v = 0;
        end else if (beam_ce) begin
            if (m_h == 226 + (m_v % 2)) begin
                m_h = 0;
                m_v = (m_v == 261) ? 0 : m_v + 1;
            end else begin
                m_h = m_h + 1;
            end
        end
        if (cycles == 190000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=<190000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic logic [14:0] setclr(logic [14:0] r, logic [15:0] d);
        return d[15] ? (r | d[14:0]) : (r & ~d[14:0]);
    endfunction

    function automatic logic [15:0] exp_read(logic [11:0] a);
        logic [11:0] w = a & 12'hFFE;
        if (w == 12'h002) return {1'b0, m_dma} | blit_status;
        if (w == 12'h004) return 16'(m_v >> 8);
        if (w == 12'h006) return {8'(m_h), 8'(m_v)};
        if (w >= 12'h110 && w <= 12'h11A) return 16'hFFFF;
        return 16'h0000;
    endfunction

    function automatic logic exp_irq();
        return m_ien[14] && ((m_ien[13:0] & m_req[13:0]) != 0);
    endfunction

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [15:0] d, logic ce);
        logic [11:0] w = a & 12'hFFE;
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; beam_ce = ce;
        @(posedge clk);
        if (w == 12'h096) m_dma = setclr(m_dma, d);
        if (w == 12'h09A) m_ien = setclr(m_ien, d);
        if (w == 12'h09C) m_req = setclr(m_req, d);
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; beam_ce = 1'b0;
    endtask

    task automatic rd_chk(string tag, logic [11:0] a);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp_read(a));
        bus_sel = 1'b0;
    endtask

    task automatic rd_lit(string tag, logic [11:0] a, logic [15:0] e);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        chk(tag, bus_rdata, e);
        bus_sel = 1'b0;
    endtask

    task automatic irq_chk(string tag, logic e);
        @(negedge clk);
        #1;
        chk(tag, 16'(irq_out), 16'(e));
    endtask

    task automatic run_ce(int n);
        @(negedge clk);
        beam_ce = 1'b1;
        repeat (n) @(posedge clk);
        @(negedge clk);
        beam_ce = 1'b0;
    endtask

    initial begin
        void'($urandom(32'h5EED_2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R11 reset state
        rd_lit("R11 dma", 12'h002, 16'h0000);
        rd_lit("R11 pos", 12'h006, 16'h0000);
        irq_chk("R11 irq", 1'b0);

        // R1 R2 R3
        wr(12'h096, 16'h8005, 1'b0);
        rd_lit("R1 set", 12'h002, 16'h0005);
        wr(12'h096, 16'h0004, 1'b0);
        rd_lit("R2 clear", 12'h002, 16'h0001);
        blit_status = 16'h4000;
        rd_lit("R3 status or", 12'h002, 16'h4001);
        blit_status = 16'h0000;

        // R5 odd address aliases
        wr(12'h097, 16'h8010, 1'b0);
        rd_lit("R5 alias", 12'h003, 16'h0011);

        // R4 interrupt logic
        wr(12'h09A, 16'h8008, 1'b0);
        wr(12'h09C, 16'h8008, 1'b0);
        irq_chk("R4 no master", 1'b0);
        wr(12'h09A, 16'hC000, 1'b0);
        irq_chk("R4 master on", 1'b1);
        wr(12'h09C, 16'h0008, 1'b0);
        irq_chk("R4 req cleared", 1'b0);
        wr(12'h09C, 16'h8009, 1'b0);
        irq_chk("R4 req again", 1'b1);

        // R10 foreign and read-only writes
        wr(12'h180, 16'hFFFF, 1'b0);
        wr(12'h002, 16'hFFFF, 1'b0);
        wr(12'h040, 16'h7FFF, 1'b0);
        wr(12'h09E, 16'h7FFF, 1'b0);
        rd_lit("R10 dma untouched", 12'h002, 16'h0011);
        irq_chk("R10 irq untouched", 1'b1);
        rd_lit("R10 write-only 096", 12'h096, 16'h0000);
        rd_lit("R10 write-only 09A", 12'h09A, 16'h0000);
        rd_lit("R10 unmapped", 12'h1FE, 16'h0000);

        // R9 bitplane data reads
        rd_lit("R9 first", 12'h110, 16'hFFFF);
        rd_lit("R9 last odd", 12'h11B, 16'hFFFF);
        rd_lit("R9 below", 12'h10E, 16'h0000);
        rd_lit("R9 above", 12'h11C, 16'h0000);

        // R12 beam hold
        repeat (10) @(posedge clk);
        rd_lit("R12 hold", 12'h006, 16'h0000);

        // R6 R7 R8 beam walk
        run_ce(226);
        rd_lit("R6 even end", 12'h006, {8'd226, 8'd0});
        run_ce(1);
        rd_lit("R6 even wrap", 12'h006, {8'd0, 8'd1});
        run_ce(227);
        rd_lit("R6 odd long", 12'h006, {8'd227, 8'd1});
        run_ce(1);
        rd_lit("R7 next line", 12'h006, {8'd0, 8'd2});
        run_ce(127 * 455);
        rd_lit("R8 high read", 12'h004, 16'h0001);
        rd_lit("R8 low read", 12'h006, {8'd0, 8'd0});
        run_ce(3 * 455 - 1);
        rd_lit("R7 last line", 12'h006, {8'd227, 8'd5});
        run_ce(1);
        rd_lit("R7 frame wrap", 12'h006, 16'h0000);
        rd_lit("R7 frame wrap hi", 12'h004, 16'h0000);

        // random mix against the model
        for (int i = 0; i < 4000; i++) begin
            int op = $urandom % 4;
            if (op == 0) begin
                int pick = $urandom % 5;
                logic [11:0] a;
                case (pick)
                    0: a = 12'h096;
                    1: a = 12'h09A;
                    2: a = 12'h09C;
                    3: a = 12'h09D;
                    default: a = 12'($urandom);
                endcase
                wr(a, 16'($urandom), 1'($urandom));
                irq_chk("R4 random irq", exp_irq());
            end else if (op == 1) begin
                blit_status = 16'($urandom) & 16'h6000;
                rd_chk("R3 random dma", 12'h002 | 12'($urandom % 2));
            end else if (op == 2) begin
                rd_chk("R10 random read", 12'($urandom));
            end else begin
                run_ce(1 + $urandom % 40);
                rd_chk("R8 random pos", 12'h006);
                rd_chk("R8 random hi", 12'h004);
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule